// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block lets a processor read a fixed set of configuration items through a small register window. A 16-bit key written to the selector names one item and rewinds its read position to the first byte. Each later read of the data window returns the next bytes of that item and moves the position forward. Past the end of the item, reads return zeros. Items sit in a built-in table split into two banks: a generic bank and an architecture-local bank. Each item has a length and byte contents that the table computes.

The request side carries an address-space code, an access size and a byte offset. Space 0 is a combined port, where the access size decides between a data read, an ignored write and a selector load. Spaces 1 and 2 are the split control and data registers. A controller with states ST_IDLE, ST_STREAM and ST_REPLY serves one access at a time:

- ST_IDLE to ST_STREAM on an accepted data read.
- ST_IDLE to ST_REPLY on any other accepted access.
- ST_STREAM to ST_REPLY after the last byte of the read.
- ST_REPLY to ST_IDLE after the one-cycle response.

Top module: `cfg_item_port`

## Requirements
- R1: After reset the signature item (key 0x0000) is selected at offset 0. `acc_ready` is 1 and `rsp_valid` is 0. A 4-byte data read returns 0x43464749, the ASCII string "CFGI".
- R2: Key layout: bit 15 picks the bank (0 generic, 1 local) and bits 14:0 are the index. A selector load takes the key from `acc_wdata[15:0]` and sets the read offset to 0.
- R3: A key whose index is NUM_ENTRIES or more selects nothing, and every read returns zero.
- R4: Item contents. Generic entry 0 is the 4-byte signature. Generic entry k>0 has length k. Local entry k has length (2k mod 7). Byte j of any other item is 128*bank + 16*k + j.
- R5: A read of n bytes (`acc_size` codes 0..3 mean 1, 2, 4, 8 bytes) takes item bytes in order. Each byte is shifted in as the least significant byte of `rsp_data`, and the offset advances once per byte taken.
- R6: If the item ends before n bytes are taken, the result is shifted left by 8 bits per missing byte, so the padding is zeros on the right.
- R7: An item of zero length, or one whose offset already equals its length, returns zero and leaves the offset unchanged.
- R8: Data writes, in any size on space 2 and as 1-byte writes on space 0, are accepted. They change neither the key nor the offset.
- R9: Combined port (space 0): a 1-byte read is a data read, a 1-byte write is ignored and a 2-byte write loads the selector. Any other size or direction is rejected.
- R10: Split mapping: space 1 accepts only 2-byte writes, as selector loads. Space 2 accepts an access only at `acc_offset` 0. Space 3 rejects everything.
- R11: A rejected access answers with `rsp_err`=1 and `rsp_data`=0, and it changes neither the key nor the offset.
- R12: `acc_ready` is high only in ST_IDLE. An n-byte read answers with a one-cycle `rsp_valid` n+1 clock edges after acceptance. Any other access answers one edge after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request, taken when acc_ready is high |
| acc_ready | output | 1 | Block is idle and can take an access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_space | input | 2 | 0 combined, 1 control, 2 data, 3 unmapped |
| acc_size | input | 2 | log2 of access size in bytes |
| acc_offset | input | 3 | Byte offset within the register window |
| acc_wdata | input | 16 | Write data (selector key) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Access was rejected |
| rsp_data | output | 8*DATA_MAX_BYTES | Read result, zero unless a read returns data |

## Verification
A single multi-byte read can both consume the last item bytes and begin zero padding, so byte fetch and padding happen in the same access. Reads of 8 bytes from a 3-byte item and of 2 bytes from an item with one byte left provoke this case. The bench's behavioural model computes the expected value and compares it, together with the exact response cycle, on every clock. A rejected selector write placed between two 1-byte reads of one item shows that rejection and offset advance do not disturb each other.

// File: rtl/cfg_item_pkg.sv
package cfg_item_pkg;

    typedef enum logic [1:0] {
        SP_COMBO = 2'd0,
        SP_CTRL  = 2'd1,
        SP_DATA  = 2'd2,
        SP_NONE  = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        OP_REJECT = 2'd0,
        OP_SELECT = 2'd1,
        OP_READ   = 2'd2,
        OP_IGNORE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_REPLY  = 2'd2
    } state_e;

    localparam int KEY_W    = 16;
    localparam int BANK_BIT = 15;
    localparam int IDX_W    = 15;
    localparam logic [KEY_W-1:0] SIG_KEY = '0;
    localparam int SIG_LEN  = 4;

    // Signature item text, "CFGI"
    function automatic logic [7:0] sig_byte(input int unsigned pos);
        case (pos)
            0:       return 8'h43;
            1:       return 8'h46;
            2:       return 8'h47;
            default: return 8'h49;
        endcase
    endfunction

endpackage

// File: rtl/cfg_item_decode.sv
module cfg_item_decode
    import cfg_item_pkg::*;
#(
    parameter int DATA_MAX_BYTES = 8
) (
    input  logic [1:0] space,
    input  logic       write,
    input  logic [1:0] size,
    input  logic [2:0] offset,
    output op_e        op
);
    localparam int MAX_CODE = $clog2(DATA_MAX_BYTES);

    logic size_fits;
    assign size_fits = (int'(size) <= MAX_CODE);

    always_comb begin
        op = OP_REJECT;
        unique case (space_e'(space))
            SP_COMBO: begin
                if (size == 2'd0)
                    op = write ? OP_IGNORE : OP_READ;
                else if (size == 2'd1 && write)
                    op = OP_SELECT;
            end
            SP_CTRL: begin
                if (size == 2'd1 && write)
                    op = OP_SELECT;
            end
            SP_DATA: begin
                if (offset == 3'd0 && size_fits)
                    op = write ? OP_IGNORE : OP_READ;
            end
            SP_NONE: op = OP_REJECT;
        endcase
    end
endmodule

// File: rtl/cfg_item_rom.sv
module cfg_item_rom
    import cfg_item_pkg::*;
#(
    parameter int NUM_ENTRIES = 6,
    parameter int ITEM_BYTES  = 8,
    parameter int LEN_W       = $clog2(ITEM_BYTES + 1)
) (
    input  logic             bank,
    input  logic [IDX_W-1:0] idx,
    input  logic [LEN_W-1:0] off,
    output logic             present,
    output logic [LEN_W-1:0] len,
    output logic [7:0]       data
);
    localparam int ENT_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    logic [LEN_W-1:0] len_tab [2][NUM_ENTRIES];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_ent
            localparam int RAW = (b == 0) ? ((k == 0) ? SIG_LEN : k) : ((2 * k) % 7);
            localparam int LIM = (RAW > ITEM_BYTES) ? ITEM_BYTES : RAW;
            assign len_tab[b][k] = LEN_W'(LIM);
        end
    end

    logic [ENT_W-1:0] sel;

    always_comb begin
        present = (idx < IDX_W'(NUM_ENTRIES));
        sel     = present ? idx[ENT_W-1:0] : '0;
        len     = present ? len_tab[bank][sel] : '0;
        if (!bank && sel == '0)
            data = sig_byte(int'(off));
        else
            data = {bank, 3'(sel), 4'(off)};
    end
endmodule

// File: rtl/cfg_item_packer.sv
module cfg_item_packer #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         shift,
    input  logic         take,
    input  logic [7:0]   byte_in,
    output logic [W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (clr)
            acc <= '0;
        else if (shift)
            acc <= {acc[W-9:0], (take ? byte_in : 8'h00)};
    end
endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
    import cfg_item_pkg::*;
#(
    parameter int NUM_ENTRIES    = 6,
    parameter int ITEM_BYTES     = 8,
    parameter int DATA_MAX_BYTES = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        acc_valid,
    output logic                        acc_ready,
    input  logic                        acc_write,
    input  logic [1:0]                  acc_space,
    input  logic [1:0]                  acc_size,
    input  logic [2:0]                  acc_offset,
    input  logic [15:0]                 acc_wdata,
    output logic                        rsp_valid,
    output logic                        rsp_err,
    output logic [8*DATA_MAX_BYTES-1:0] rsp_data
);
    localparam int LEN_W  = $clog2(ITEM_BYTES + 1);
    localparam int CNT_W  = $clog2(DATA_MAX_BYTES) + 1;
    localparam int DATA_W = 8 * DATA_MAX_BYTES;

    state_e           state_q, state_nx;
    op_e              op;
    logic [KEY_W-1:0] key_q;
    logic [LEN_W-1:0] off_q;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;
    logic             cur_present;
    logic [LEN_W-1:0] cur_len;
    logic [7:0]       cur_byte;
    logic             have_byte;
    logic             accept;
    logic [DATA_W-1:0] packed_q;

    cfg_item_decode #(.DATA_MAX_BYTES(DATA_MAX_BYTES)) u_decode (
        .space  (acc_space),
        .write  (acc_write),
        .size   (acc_size),
        .offset (acc_offset),
        .op     (op)
    );

    cfg_item_rom #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .ITEM_BYTES  (ITEM_BYTES),
        .LEN_W       (LEN_W)
    ) u_rom (
        .bank    (key_q[BANK_BIT]),
        .idx     (key_q[IDX_W-1:0]),
        .off     (off_q),
        .present (cur_present),
        .len     (cur_len),
        .data    (cur_byte)
    );

    assign accept    = (state_q == ST_IDLE) && acc_valid;
    assign have_byte = cur_present && (off_q < cur_len);

    cfg_item_packer #(.W(DATA_W)) u_packer (
        .clk     (clk),
        .rst     (rst),
        .clr     (accept),
        .shift   (state_q == ST_STREAM),
        .take    (have_byte),
        .byte_in (cur_byte),
        .acc     (packed_q)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (acc_valid) state_nx = (op == OP_READ) ? ST_STREAM : ST_REPLY;
            ST_STREAM: if (cnt_q == CNT_W'(1)) state_nx = ST_REPLY;
            ST_REPLY:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Selector, offset and byte counter
    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= SIG_KEY;
            off_q <= '0;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (acc_valid) begin
                        err_q <= (op == OP_REJECT);
                        cnt_q <= CNT_W'(1) << acc_size;
                        if (op == OP_SELECT) begin
                            key_q <= acc_wdata;
                            off_q <= '0;
                        end
                    end
                end
                ST_STREAM: begin
                    cnt_q <= cnt_q - CNT_W'(1);
                    if (have_byte)
                        off_q <= off_q + LEN_W'(1);
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        acc_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_REPLY);
        rsp_err   = rsp_valid && err_q;
        rsp_data  = rsp_valid ? packed_q : '0;
    end
endmodule

// File: rtl/cfg_item_port_chk.sv
module cfg_item_port_chk #(
    parameter int LEN_W  = 4,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_ready,
    input logic              acc_write,
    input logic [1:0]        acc_space,
    input logic [1:0]        acc_size,
    input logic [15:0]       acc_wdata,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_data,
    input logic [15:0]       key_q,
    input logic [LEN_W-1:0]  off_q,
    input logic [LEN_W-1:0]  cur_len
);
    AST_RSP_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !acc_ready); // R12

    AST_READY_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> acc_ready); // R12

    AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_data == '0)); // R11

    AST_SEL_REWIND: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_ready && acc_write && acc_size == 2'd1 &&
         (acc_space == 2'd0 || acc_space == 2'd1))
        |=> (off_q == '0 && key_q == $past(acc_wdata))); // R2

    AST_DATA_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_ready && acc_write && acc_space == 2'd2)
        |=> ($stable(off_q) && $stable(key_q))); // R8

    AST_OFF_IN_ITEM: assert property (@(posedge clk) disable iff (rst)
        off_q <= cur_len); // R7
endmodule

bind cfg_item_port cfg_item_port_chk #(.LEN_W(LEN_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_ready (acc_ready),
    .acc_write (acc_write),
    .acc_space (acc_space),
    .acc_size  (acc_size),
    .acc_wdata (acc_wdata),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_data  (rsp_data),
    .key_q     (key_q),
    .off_q     (off_q),
    .cur_len   (cur_len)
);

// File: tb/cfg_item_port_bench.sv
module cfg_item_port_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_ready;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_space = 2'd0;
    logic [1:0]  acc_size = 2'd0;
    logic [2:0]  acc_offset = 3'd0;
    logic [15:0] acc_wdata = 16'd0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_data;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int exp_cycle = -10;
    logic [63:0] exp_data = '0;
    logic        exp_err = 1'b0;
    string       exp_tag = "R12";

    // Behavioural item model
    int m_key = 0;
    int m_off = 0;
    localparam int NENT = 6;

    always #2.5 clk = ~clk;

    cfg_item_port u_cfg_item_port (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_ready(acc_ready),
        .acc_write(acc_write), .acc_space(acc_space), .acc_size(acc_size),
        .acc_offset(acc_offset), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_data(rsp_data)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int m_len(int bank, int k);
        if (k >= NENT) return 0;
        if (bank == 0) return (k == 0) ? 4 : k;
        return (2 * k) % 7;
    endfunction

    function automatic int m_byte(int bank, int k, int j);
        byte unsigned sig [4] = '{8'h43, 8'h46, 8'h47, 8'h49};
        if (bank == 0 && k == 0) return int'(sig[j]);
        return 128 * bank + 16 * k + j;
    endfunction

    // 0 reject, 1 select, 2 read, 3 ignore
    function automatic int m_op(int sp, int wr, int sz, int ofs);
        case (sp)
            0: begin
                if (sz == 0) return wr ? 3 : 2;
                if (sz == 1 && wr) return 1;
                return 0;
            end
            1: return (sz == 1 && wr) ? 1 : 0;
            2: begin
                if (ofs != 0) return 0;
                return wr ? 3 : 2;
            end
            default: return 0;
        endcase
    endfunction

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (rsp_valid !== (cyc == exp_cycle)) begin
                failures++;
                $display("FAIL %s rsp_valid at cycle %0d act=%0d exp=%0d",
                         exp_tag, cyc, rsp_valid, (cyc == exp_cycle));
            end
            if (cyc == exp_cycle) begin
                checks++;
                if (rsp_data !== exp_data || rsp_err !== exp_err) begin
                    failures++;
                    $display("FAIL %s response act=%h/%0d exp=%h/%0d",
                             exp_tag, rsp_data, rsp_err, exp_data, exp_err);
                end
            end
        end
    end

    task automatic access(input string tag, input int sp, input int wr,
                          input int sz, input int ofs, input int wd);
        int op;
        int n;
        int bank;
        int k;
        logic [63:0] v;
        while (!acc_ready) @(negedge clk);
        op = m_op(sp, wr, sz, ofs);
        v = '0;
        n = 1 << sz;
        if (op == 1) begin
            m_key = wd & 16'hFFFF;
            m_off = 0;
        end else if (op == 2) begin
            bank = (m_key >> 15) & 1;
            k = m_key & 16'h7FFF;
            for (int i = 0; i < n; i++) begin
                if (k < NENT && m_off < m_len(bank, k)) begin
                    v = (v << 8) | 64'(m_byte(bank, k, m_off));
                    m_off++;
                end else begin
                    v = v << 8;
                end
            end
        end
        acc_valid  = 1'b1;
        acc_write  = wr[0];
        acc_space  = sp[1:0];
        acc_size   = sz[1:0];
        acc_offset = ofs[2:0];
        acc_wdata  = wd[15:0];
        exp_data   = v;
        exp_err    = (op == 0);
        exp_tag    = tag;
        exp_cycle  = cyc + 1 + ((op == 2) ? n : 0);
        @(negedge clk);
        acc_valid = 1'b0;
        while (cyc < exp_cycle + 1) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL R12 watchdog act=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        checks++;
        if (acc_ready !== 1'b1 || rsp_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset state act=%0d/%0d exp=1/0", acc_ready, rsp_valid);
        end
        access("R1", 2, 0, 2, 0, 0);          // signature, 4 bytes
        access("R7", 2, 0, 0, 0, 0);          // exhausted
        access("R7", 2, 0, 1, 0, 0);
        access("R2", 1, 1, 1, 0, 16'h0003);   // ctrl select generic 3
        access("R6", 2, 0, 3, 0, 0);          // 8 bytes from 3-byte item
        access("R9", 0, 1, 1, 0, 16'h0005);   // combined select
        access("R9", 0, 0, 0, 0, 0);
        access("R9", 0, 0, 0, 0, 0);
        access("R8", 2, 1, 3, 0, 16'h0001);   // data write ignored
        access("R5", 2, 0, 1, 0, 0);
        access("R8", 0, 1, 0, 0, 16'h0002);   // combined 1-byte write ignored
        access("R9", 0, 0, 0, 0, 0);
        access("R4", 1, 1, 1, 0, 16'h8002);   // local 2
        access("R4", 2, 0, 2, 0, 0);
        access("R7", 1, 1, 1, 0, 16'h8000);   // local 0, zero length
        access("R7", 2, 0, 1, 0, 0);
        access("R3", 1, 1, 1, 0, 16'h0006);   // index out of range
        access("R3", 2, 0, 2, 0, 0);
        access("R3", 0, 1, 1, 0, 16'h7FFF);
        access("R3", 0, 0, 0, 0, 0);
        access("R2", 1, 1, 1, 0, 16'h0004);   // generic 4
        access("R5", 2, 0, 0, 0, 0);
        access("R11", 1, 1, 0, 0, 16'h0001);  // rejected 1-byte ctrl write
        access("R11", 2, 0, 0, 0, 0);         // continues at offset 1
        access("R9", 0, 0, 1, 0, 0);          // combined 2-byte read rejected
        access("R9", 0, 1, 2, 0, 16'h0001);   // combined 4-byte write rejected
        access("R10", 1, 0, 1, 0, 0);         // ctrl read rejected
        access("R10", 2, 0, 0, 1, 0);         // data offset 1 rejected
        access("R10", 3, 0, 0, 0, 0);         // unmapped
        access("R11", 2, 0, 1, 0, 0);         // remaining bytes of item 4
        access("R2", 0, 1, 1, 0, 16'h0004);   // reselect rewinds
        access("R2", 2, 0, 0, 0, 0);
        access("R4", 1, 1, 1, 0, 16'h8005);   // local 5, length 3
        access("R5", 2, 0, 1, 0, 0);
        access("R6", 2, 0, 1, 0, 0);          // one byte then padding
        access("R7", 2, 0, 3, 0, 0);
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule